// File: doc/BRIEF.md
# Periodic Down-Count Timer

This block is a small timer peripheral that sits on a simple register bus. A prescaler derives a fixed 1 MHz tick from the system clock. While the timer runs, a 16-bit counter drops by one on every tick. When it is already at zero, the next tick refills it from a reload register, so it counts periodically. Software can read the live count at any time. Rollover signals nothing, so the block has no interrupt output.

Three 32-bit word registers sit in a 256-byte window. Only full-word accesses exist. A control word holds a start bit and a self-clear bit, and the self-clear bit overrides everything else in the same write. Once the timer has started, it runs until the self-clear bit or the hardware reset stops it. Writing the reload register also loads the live counter and restarts the tick phase.

Top module: `ptmr_timer`

## Requirements
- R1: After hardware reset (active-low `rst_n`), the control, reload and count registers all read zero, and the count does not change until the timer is started.
- R2: A write to the reload register (offset 0x08) keeps bits [15:0] of the data and reads back with bits [31:16] zero. In the cycle after the write, the count register also reads the new value.
- R3: A read of the count register (offset 0x0C) returns the live counter in bits [15:0], with bits [31:16] zero. A write to offset 0x0C changes nothing.
- R4: A control write (offset 0x00) with bit 31 set clears control, reload and count to zero, stops counting and resets the tick phase. It does not store the written word, and it wins over bit 0 in the same word.
- R5: A control write with bit 0 set and bit 31 clear stores the whole 32-bit word and starts counting.
- R6: A control write with both bit 0 and bit 31 clear stores the word but leaves a running timer running.
- R7: While running, the counter changes only on a tick, and a tick comes once every CLK_HZ/TICK_HZ system clocks. A tick with the counter above zero decrements it. A tick with the counter at zero loads the reload value.
- R8: A reload write or a self-clear write restarts the tick phase, so the next tick comes a full CLK_HZ/TICK_HZ clocks after the write. While stopped, the phase stays at its start.
- R9: A read at any offset other than 0x00, 0x08 and 0x0C returns zero, and a write there changes no register. `bus_rdata` is zero whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |

## Verification
On every cycle, the assertions check that the counter holds between ticks, drops by one or refills from reload on a tick, and loads at once on a reload write. They also check that a self-clear write leaves every register at zero and stopped, and that only self-clear ever stops a running timer. The prescaler's range and restart are checked the same way. The exact tick spacing through whole periods is shown only by the bench's scenarios, which compare every read against a cycle-level model. The same holds for the interaction of a reload write with an imminent tick and for the read-back of stored control words.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DATA_W = 32;

    // Word offsets inside the 256-byte window
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_RELOAD = 8'h08;
    localparam logic [7:0] OFF_COUNT  = 8'h0C;

    // Control word bit positions
    localparam int BIT_START = 0;
    localparam int BIT_CLEAR = 31;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [15:0]       reload;
        logic              run;
    } regs_t;

endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              run_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              clear_o
);

    localparam int PAD_W = DATA_W - CNT_W;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  reload;
        logic              run;
    } state_t;

    state_t s_d, s_q;

    logic wr, rd, hit_ctrl, hit_reload, hit_count, clr;

    always_comb begin
        wr         = valid_i && write_i;
        rd         = valid_i && !write_i;
        hit_ctrl   = (addr_i == ADDR_W'(OFF_CTRL));
        hit_reload = (addr_i == ADDR_W'(OFF_RELOAD));
        hit_count  = (addr_i == ADDR_W'(OFF_COUNT));
        clr        = wr && hit_ctrl && wdata_i[BIT_CLEAR];

        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (wr && hit_ctrl) begin
                s_d.ctrl = wdata_i;
                if (wdata_i[BIT_START]) begin
                    s_d.run = 1'b1;
                end
            end
            if (wr && hit_reload) begin
                s_d.reload = wdata_i[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            if (hit_ctrl) begin
                rdata_o = s_q.ctrl;
            end else if (hit_reload) begin
                rdata_o = {{PAD_W{1'b0}}, s_q.reload};
            end else if (hit_count) begin
                rdata_o = {{PAD_W{1'b0}}, cnt_i};
            end
        end
    end

    assign run_o      = s_q.run;
    assign reload_o   = s_q.reload;
    assign load_o     = wr && hit_reload;
    assign load_val_o = wdata_i[CNT_W-1:0];
    assign clear_o    = clr;

    // R4: self-clear leaves every register at zero and stopped
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && addr_i == ADDR_W'(OFF_CTRL) && wdata_i[BIT_CLEAR])
        |=> (s_q.ctrl == '0 && s_q.reload == '0 && !s_q.run));

    // R6: a running timer stays running unless self-clear is written
    p_run_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !clr) |=> s_q.run);

    // R9: writes outside the map change no register
    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && !hit_ctrl && !hit_reload)
        |=> (s_q.ctrl == $past(s_q.ctrl) && s_q.reload == $past(s_q.reload)
             && s_q.run == $past(s_q.run)));

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        tick_o = run_i && (div_q == LAST);
        if (restart_i || !run_i || tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // R7: phase never leaves its range
    p_div_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);

    // R8: restart returns the phase to its start
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> div_q == '0);

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i) begin
            if (cnt_q == '0) begin
                cnt_d = reload_i;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    // R7: no change between ticks
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i && !clear_i) |=> $stable(cnt_q));

    // R7: a tick from zero refills from reload
    p_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && !clear_i && cnt_q == '0) |=> cnt_q == $past(reload_i));

    // R7: a tick above zero steps down by one
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && !clear_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R2: reload write lands in the live counter
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> cnt_q == $past(load_val_i));

endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer
    import ptmr_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 1_000_000,
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int DIV = (CLK_HZ / TICK_HZ > 1) ? CLK_HZ / TICK_HZ : 2;

    logic             run, load, clear, tick;
    logic [CNT_W-1:0] reload, load_val, cnt;

    ptmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (bus_valid),
        .write_i    (bus_write),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .cnt_i      (cnt),
        .rdata_o    (bus_rdata),
        .run_o      (run),
        .reload_o   (reload),
        .load_o     (load),
        .load_val_o (load_val),
        .clear_o    (clear)
    );

    ptmr_prescaler #(.DIV(DIV)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (load || clear),
        .tick_o    (tick)
    );

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (load_val),
        .clear_i    (clear),
        .reload_i   (reload),
        .cnt_o      (cnt)
    );

    // R3: count read never shows upper bits
    p_count_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == ADDR_W'(OFF_COUNT))
        |-> bus_rdata[31:16] == 16'h0);

    // R1: stopped timer keeps its count
    p_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load && !clear) |=> $stable(cnt));

endmodule

// File: tb/ptmr_timer_tb.sv
module ptmr_timer_tb;

    localparam int CLK_HZ  = 5_000_000;
    localparam int TICK_HZ = 1_000_000;
    localparam int DIV     = CLK_HZ / TICK_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference state
    logic [31:0] m_ctrl = 0;
    int          m_reload = 0;
    int          m_cnt = 0;
    bit          m_run = 0;
    int          m_phase = 0;

    ptmr_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0; m_reload = 0; m_cnt = 0; m_run = 0; m_phase = 0;
        end else begin
            bit fire;
            fire = m_run && (m_phase == DIV - 1);
            if (bus_valid && bus_write && bus_addr == 8'h00 && bus_wdata[31]) begin
                m_ctrl = 0; m_reload = 0; m_cnt = 0; m_run = 0; m_phase = 0;
            end else if (bus_valid && bus_write && bus_addr == 8'h08) begin
                m_reload = bus_wdata & 32'hFFFF;
                m_cnt = m_reload;
                m_phase = 0;
            end else begin
                if (fire) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
                m_phase = (!m_run || fire) ? 0 : m_phase + 1;
                if (bus_valid && bus_write && bus_addr == 8'h00) begin
                    m_ctrl = bus_wdata;
                    if (bus_wdata[0]) m_run = 1;
                end
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        logic [31:0] exp;
        exp = 0;
        if (bus_valid && !bus_write) begin
            case (bus_addr)
                8'h00: exp = m_ctrl;
                8'h08: exp = m_reload;
                8'h0C: exp = m_cnt;
                default: exp = 0;
            endcase
        end
        vectors++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h rdata=%h expected %h", tag, bus_addr, bus_rdata, exp);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic idle_read(input logic [7:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = 32'h0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 8'h0C; bus_wdata = 32'hFFFF_FFFF;
        end
    endtask

    initial begin
        // R1: reset state and a stopped count
        tag = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle_read(8'h00, 1); idle_read(8'h08, 1); idle_read(8'h0C, 12);

        // R2: reload write truncates and loads the count
        tag = "R2";
        wr(8'h08, 32'hABCD_1234);
        idle_read(8'h08, 1); idle_read(8'h0C, 8);

        // R3: write to count offset ignored, upper bits zero
        tag = "R3";
        wr(8'h0C, 32'h5555_5555);
        idle_read(8'h0C, 4);

        // R5: start stores the full word
        tag = "R5";
        wr(8'h00, 32'h0000_0101);
        idle_read(8'h00, 1);
        tag = "R7";
        idle_read(8'h0C, 40);

        // R8: small reload, restart phase mid-period, wrap through zero
        tag = "R8";
        wr(8'h08, 32'h0000_0003);
        idle_read(8'h0C, 3);
        wr(8'h08, 32'hFFFF_0002);
        tag = "R7";
        idle_read(8'h0C, 50);

        // R6: clearing the start bit keeps it running
        tag = "R6";
        wr(8'h00, 32'h0000_0100);
        idle_read(8'h00, 1);
        idle_read(8'h0C, 30);

        // R9: unmapped offsets and no read presented
        tag = "R9";
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h09, 32'h0000_0007);
        wr(8'hFC, 32'h8000_0000);
        idle_read(8'h04, 1); idle_read(8'h10, 1); idle_read(8'hFC, 1);
        quiet(5);
        idle_read(8'h08, 1); idle_read(8'h00, 1); idle_read(8'h0C, 10);

        // R4: self-clear beats start in the same word
        tag = "R4";
        wr(8'h08, 32'h0000_0009);
        wr(8'h00, 32'h8000_0001);
        idle_read(8'h00, 1); idle_read(8'h08, 1); idle_read(8'h0C, 20);

        // R8: after self-clear, restart and check first tick spacing
        tag = "R8";
        wr(8'h08, 32'h0000_0004);
        wr(8'h00, 32'h0000_0001);
        idle_read(8'h0C, 45);

        // R1: hardware reset in the middle of a run
        tag = "R1";
        @(posedge clk); #2 rst_n = 1'b0;
        idle_read(8'h0C, 3);
        #0 rst_n = 1'b1;
        idle_read(8'h00, 1); idle_read(8'h08, 1); idle_read(8'h0C, 15);

        quiet(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule